// File: doc/BRIEF.md
# Windowed Sum From Streamed Summed-Area Tables

This block takes a raster stream of summed-area table entries and returns, for every pixel, three totals over a 7x7 neighbourhood centred on that pixel. The totals are the count of valid (unmasked) pixels, the sum of valid pixel values and the sum of their squares. A later threshold stage uses these totals to estimate a local mean and variance. Each clock may carry one pack of `PACK` neighbouring pixels. Every pixel in the pack has its cumulative mask count, cumulative value sum, cumulative squared sum and its raw value. A window total is built from four cumulative corner entries as bottom-right minus bottom-left minus top-right plus top-left.

Rows that arrived earlier are held in an eight-row ring buffer. The bottom corners always lie on the newest row. For a normal output, the pack holding its right-hand bottom corners is taken straight from the input in the cycle it arrives, while that same pack is written into the ring. This lets the block accept one pack per clock with no stall. The output trails the input by three rows. When a frame's last pack has been accepted, the block drains the final three rows by itself, using the last row as the bottom edge. Windows that reach past the image edges are cut off at those edges.

Top module: `sat_window_sum`

## Requirements
- R1: After reset `outValid` is low, and it stays low until the first output pack is due.
- R2: For a pixel (row y, column x) whose window lies fully inside the image, `outMask`, `outSum` and `outSq` hold the totals of mask, value and squared value over rows y-3..y+3 and columns x-3..x+3. Lane j of a pack k is column `PACK*k+j` and sits in bits `[j*w +: w]` of each vector of field width w. Pack k covers columns `PACK*k`..`PACK*k+PACK-1`.
- R3: A window that reaches beyond column 0 or column `IMG_W-1` is cut off at that column.
- R4: A window that reaches above row 0 or below row `IMG_H-1` is cut off at that row.
- R5: For pack q < `IMG_W/PACK`-1 of row y, with y+3 below `IMG_H`, the output pack is valid in the cycle that directly follows the clock edge that accepts pack q+1 of row y+3.
- R6: The last pack of row y, with y+3 below `IMG_H`, is valid one cycle later than the edge that accepts the last pack of row y+3.
- R7: Let L be the edge that accepts the last pack of a frame. Rows `IMG_H-3`..`IMG_H-1` then appear in raster order on the consecutive edges L+2 onward, with no further input.
- R8: `outPix` carries each pixel's raw value, aligned with its window totals.
- R9: Idle input cycles produce no output other than pending row-end and drain packs. Each frame yields exactly `IMG_H*IMG_W/PACK` packs, in raster order.
- R10: Every output mask count is at most 49. When every input value is non-negative and squares are summed, the square total is never below the value total.
- R11: No input may arrive from the acceptance of a frame's last pack until the drain ends. The next frame may start on the edge right after the drain ends.
- R12: With input valid on every clock, the block accepts one pack per clock and never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A pack is present on the inputs this cycle |
| inMask | input | PACK*MASK_W | Cumulative mask counts, one per lane |
| inSum | input | PACK*SUM_W | Cumulative value sums, one per lane |
| inSq | input | PACK*SQ_W | Cumulative squared-value sums, one per lane |
| inPix | input | PACK*PIX_W | Raw pixel values, one per lane |
| outValid | output | 1 | An output pack is present |
| outMask | output | PACK*6 | Windowed valid-pixel counts |
| outSum | output | PACK*SUM_W | Windowed value sums |
| outSq | output | PACK*SQ_W | Windowed squared-value sums |
| outPix | output | PACK*PIX_W | Raw pixel values, delayed to match |

## Verification
The bench builds each expected total straight from the pixel data rather than from table corners. A design that takes a wrong corner, such as reading the top corners one row off or reusing the current pack where the right corner belongs in the next pack, therefore gives wrong totals on the affected pixels. The left and right columns and the first and last three rows are checked as edge cases: a wrong column clamp or a missing zero for a corner at index -1 shows up there as a miscount. Each output pack is also checked for the exact clock edge on which it appears. Three input patterns are used: a continuous stream, a stream with gaps, and an all-valid frame of maximum values. A row-end pack that is lost or sent late, a drain that starts at the wrong time or uses the wrong bottom row, and an output produced during an idle gap all show up as timing or ordering failures.

// File: rtl/wsum_pkg.sv
package wsum_pkg;

  // fixed window geometry: 7x7 centred on the output pixel
  localparam int WIN_SIDE   = 7;
  localparam int HALF       = (WIN_SIDE - 1) / 2;
  localparam int TOP_OFF    = HALF + 1;
  localparam int WIN_MASK_W = $clog2(WIN_SIDE * WIN_SIDE + 1);
  localparam int IDX_W      = 16;
  localparam int RING       = 8;
  localparam int SLOT_W     = $clog2(RING);

  typedef enum logic [1:0] {
    JOB_NONE  = 2'd0,
    JOB_LIVE  = 2'd1,
    JOB_TAIL  = 2'd2,
    JOB_FLUSH = 2'd3
  } jobSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrRow;
    logic [IDX_W-1:0] wrPack;
    jobSrc_t          src;
    logic [IDX_W-1:0] outRow;
    logic [IDX_W-1:0] botRow;
    logic [IDX_W-1:0] packIdx;
  } wsumCtl_t;

endpackage

// File: rtl/wsum_ctrl.sv
module wsum_ctrl import wsum_pkg::*; #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 10,
  parameter int PACK  = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output wsumCtl_t ctl
);

  localparam int NP    = IMG_W / PACK;
  localparam int ROW_W = $clog2(IMG_H);
  localparam int PK_W  = (NP > 1) ? $clog2(NP) : 1;
  localparam int LAG   = HALF;

  logic [ROW_W-1:0] inRow, tailRow, fRow;
  logic [PK_W-1:0]  inPack, fPack;
  logic             tailPend, flushArm, flushOn;
  logic             liveJob, lastPack, lastRow;

  assign lastPack = (inPack == PK_W'(NP - 1));
  assign lastRow  = (inRow == ROW_W'(IMG_H - 1));
  assign liveJob  = inValid && (inPack != '0) && (inRow >= ROW_W'(LAG));

  // input position counters and drain sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRow    <= '0;
      inPack   <= '0;
      tailPend <= 1'b0;
      tailRow  <= '0;
      flushArm <= 1'b0;
      flushOn  <= 1'b0;
      fRow     <= '0;
      fPack    <= '0;
    end else begin
      if (inValid) begin
        if (lastPack) begin
          inPack <= '0;
          inRow  <= lastRow ? '0 : inRow + 1'b1;
        end else begin
          inPack <= inPack + 1'b1;
        end
      end
      tailPend <= inValid && lastPack && (inRow >= ROW_W'(LAG));
      tailRow  <= inRow - ROW_W'(LAG);
      flushArm <= inValid && lastPack && lastRow;
      if (flushArm) begin
        flushOn <= 1'b1;
        fRow    <= ROW_W'(IMG_H - LAG);
        fPack   <= '0;
      end else if (flushOn) begin
        if (fPack == PK_W'(NP - 1)) begin
          fPack <= '0;
          if (fRow == ROW_W'(IMG_H - 1)) flushOn <= 1'b0;
          else                           fRow    <= fRow + 1'b1;
        end else begin
          fPack <= fPack + 1'b1;
        end
      end
    end
  end

  // job selection: row-end pack, then drain, then live packs
  always_comb begin
    ctl        = '0;
    ctl.src    = JOB_NONE;
    ctl.wrEn   = inValid;
    ctl.wrRow  = IDX_W'(inRow);
    ctl.wrPack = IDX_W'(inPack);
    if (tailPend) begin
      ctl.src     = JOB_TAIL;
      ctl.outRow  = IDX_W'(tailRow);
      ctl.botRow  = IDX_W'(tailRow) + IDX_W'(LAG);
      ctl.packIdx = IDX_W'(NP - 1);
    end else if (flushOn) begin
      ctl.src     = JOB_FLUSH;
      ctl.outRow  = IDX_W'(fRow);
      ctl.botRow  = IDX_W'(IMG_H - 1);
      ctl.packIdx = IDX_W'(fPack);
    end else if (liveJob) begin
      ctl.src     = JOB_LIVE;
      ctl.outRow  = IDX_W'(inRow - ROW_W'(LAG));
      ctl.botRow  = IDX_W'(inRow);
      ctl.packIdx = IDX_W'(inPack - 1'b1);
    end
  end

  AST_NO_INPUT_WHILE_DRAINING: assert property (@(posedge clk) disable iff (!rstN)
    (flushArm || flushOn) |-> !inValid); // R11

  AST_ONE_JOB_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tailPend, flushOn, liveJob})); // R9

  AST_TAIL_AFTER_ROW_END: assert property (@(posedge clk) disable iff (!rstN)
    tailPend |-> $past(inValid)); // R6

  AST_DRAIN_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushOn) |-> $past(tailPend)); // R7

endmodule

// File: rtl/wsum_datapath.sv
module wsum_datapath import wsum_pkg::*; #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 10,
  parameter int PACK   = 4,
  parameter int PIX_W  = 8,
  parameter int MASK_W = 8,
  parameter int SUM_W  = 16,
  parameter int SQ_W   = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wsumCtl_t                   ctl,
  input  logic [PACK*MASK_W-1:0]     inMask,
  input  logic [PACK*SUM_W-1:0]      inSum,
  input  logic [PACK*SQ_W-1:0]       inSq,
  input  logic [PACK*PIX_W-1:0]      inPix,
  output logic                       outValid,
  output logic [PACK*WIN_MASK_W-1:0] outMask,
  output logic [PACK*SUM_W-1:0]      outSum,
  output logic [PACK*SQ_W-1:0]       outSq,
  output logic [PACK*PIX_W-1:0]      outPix
);

  localparam int NP   = IMG_W / PACK;
  localparam int PK_W = (NP > 1) ? $clog2(NP) : 1;
  localparam int SPAN = 3 * PACK;
  localparam int CLIP = 2 * PACK - 1;

  // ring of the most recent rows
  logic [MASK_W-1:0] ringMask [RING][NP][PACK];
  logic [SUM_W-1:0]  ringSum  [RING][NP][PACK];
  logic [SQ_W-1:0]   ringSq   [RING][NP][PACK];
  logic [PIX_W-1:0]  ringPix  [RING][NP][PACK];

  logic [SLOT_W-1:0] wrSlot, botSlot, topSlot, pixSlot;
  logic [PK_W-1:0]   wrPk, q;
  logic [IDX_W-1:0]  topRow;
  logic              topOk, isLive, lastQ;

  assign wrSlot  = ctl.wrRow[SLOT_W-1:0];
  assign wrPk    = ctl.wrPack[PK_W-1:0];
  assign botSlot = ctl.botRow[SLOT_W-1:0];
  assign pixSlot = ctl.outRow[SLOT_W-1:0];
  assign topRow  = ctl.outRow - IDX_W'(TOP_OFF);
  assign topSlot = topRow[SLOT_W-1:0];
  assign topOk   = (ctl.outRow >= IDX_W'(TOP_OFF));
  assign q       = ctl.packIdx[PK_W-1:0];
  assign isLive  = (ctl.src == JOB_LIVE);
  assign lastQ   = (q == PK_W'(NP - 1));

  logic unusedBits;
  assign unusedBits = ^{ctl.wrRow[IDX_W-1:SLOT_W], ctl.wrPack[IDX_W-1:PK_W],
                        ctl.botRow[IDX_W-1:SLOT_W], topRow[IDX_W-1:SLOT_W],
                        ctl.packIdx[IDX_W-1:PK_W]};

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      for (int j = 0; j < PACK; j++) begin
        ringMask[wrSlot][wrPk][j] <= inMask[j*MASK_W +: MASK_W];
        ringSum[wrSlot][wrPk][j]  <= inSum[j*SUM_W +: SUM_W];
        ringSq[wrSlot][wrPk][j]   <= inSq[j*SQ_W +: SQ_W];
        ringPix[wrSlot][wrPk][j]  <= inPix[j*PIX_W +: PIX_W];
      end
    end
  end

  // three-pack column windows on the bottom and top corner rows
  logic [MASK_W-1:0] botM [SPAN];
  logic [MASK_W-1:0] topM [SPAN];
  logic [SUM_W-1:0]  botS [SPAN];
  logic [SUM_W-1:0]  topS [SPAN];
  logic [SQ_W-1:0]   botQ [SPAN];
  logic [SQ_W-1:0]   topQ [SPAN];

  for (genvar i = 0; i < SPAN; i++) begin : g_span
    localparam int PO = i / PACK - 1;
    localparam int LN = i % PACK;
    logic [PK_W-1:0] pk;
    logic            ok;
    if (PO < 0) begin : g_prev
      assign pk = q - 1'b1;
      assign ok = (q != '0);
    end else if (PO == 0) begin : g_cur
      assign pk = q;
      assign ok = 1'b1;
    end else begin : g_next
      assign pk = q + 1'b1;
      assign ok = !lastQ;
    end
    if (PO > 0) begin : g_bot_new
      assign botM[i] = !ok ? '0 : isLive ? inMask[LN*MASK_W +: MASK_W] : ringMask[botSlot][pk][LN];
      assign botS[i] = !ok ? '0 : isLive ? inSum[LN*SUM_W +: SUM_W]    : ringSum[botSlot][pk][LN];
      assign botQ[i] = !ok ? '0 : isLive ? inSq[LN*SQ_W +: SQ_W]       : ringSq[botSlot][pk][LN];
    end else begin : g_bot_old
      assign botM[i] = ok ? ringMask[botSlot][pk][LN] : '0;
      assign botS[i] = ok ? ringSum[botSlot][pk][LN]  : '0;
      assign botQ[i] = ok ? ringSq[botSlot][pk][LN]   : '0;
    end
    assign topM[i] = (ok && topOk) ? ringMask[topSlot][pk][LN] : '0;
    assign topS[i] = (ok && topOk) ? ringSum[topSlot][pk][LN]  : '0;
    assign topQ[i] = (ok && topOk) ? ringSq[topSlot][pk][LN]   : '0;
  end

  // per-lane corner combination
  logic [WIN_MASK_W-1:0] laneMask [PACK];
  logic [SUM_W-1:0]      laneSum  [PACK];
  logic [SQ_W-1:0]       laneSq   [PACK];

  for (genvar j = 0; j < PACK; j++) begin : g_lane
    localparam int C0  = PACK + j - TOP_OFF;
    localparam int C1N = PACK + j + HALF;
    logic [MASK_W-1:0] aM, bM, cM, dM, wM;
    logic [SUM_W-1:0]  aS, bS, cS, dS;
    logic [SQ_W-1:0]   aQ, bQ, cQ, dQ;
    if (j + HALF > PACK - 1) begin : g_clip
      assign aM = lastQ ? botM[CLIP] : botM[C1N];
      assign cM = lastQ ? topM[CLIP] : topM[C1N];
      assign aS = lastQ ? botS[CLIP] : botS[C1N];
      assign cS = lastQ ? topS[CLIP] : topS[C1N];
      assign aQ = lastQ ? botQ[CLIP] : botQ[C1N];
      assign cQ = lastQ ? topQ[CLIP] : topQ[C1N];
    end else begin : g_inner
      assign aM = botM[C1N];
      assign cM = topM[C1N];
      assign aS = botS[C1N];
      assign cS = topS[C1N];
      assign aQ = botQ[C1N];
      assign cQ = topQ[C1N];
    end
    assign bM = botM[C0];
    assign dM = topM[C0];
    assign bS = botS[C0];
    assign dS = topS[C0];
    assign bQ = botQ[C0];
    assign dQ = topQ[C0];
    assign wM          = aM - bM - cM + dM;
    assign laneMask[j] = wM[WIN_MASK_W-1:0];
    assign laneSum[j]  = aS - bS - cS + dS;
    assign laneSq[j]   = aQ - bQ - cQ + dQ;

    AST_MASK_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (outMask[j*WIN_MASK_W +: WIN_MASK_W] <= WIN_MASK_W'(WIN_SIDE*WIN_SIDE))); // R10

    AST_SQ_COVERS_SUM: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (SQ_W'(outSum[j*SUM_W +: SUM_W]) <= outSq[j*SQ_W +: SQ_W])); // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMask  <= '0;
      outSum   <= '0;
      outSq    <= '0;
      outPix   <= '0;
    end else begin
      outValid <= (ctl.src != JOB_NONE);
      for (int j = 0; j < PACK; j++) begin
        outMask[j*WIN_MASK_W +: WIN_MASK_W] <= laneMask[j];
        outSum[j*SUM_W +: SUM_W]            <= laneSum[j];
        outSq[j*SQ_W +: SQ_W]               <= laneSq[j];
        outPix[j*PIX_W +: PIX_W]            <= ringPix[pixSlot][q][j];
      end
    end
  end

  AST_JOB_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src != JOB_NONE) |=> outValid); // R12

  AST_IDLE_GIVES_NOTHING: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.src == JOB_NONE) |=> !outValid); // R9

endmodule

// File: rtl/sat_window_sum.sv
module sat_window_sum import wsum_pkg::*; #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 10,
  parameter int PACK   = 4,
  parameter int PIX_W  = 8,
  parameter int MASK_W = 8,
  parameter int SUM_W  = 16,
  parameter int SQ_W   = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [PACK*MASK_W-1:0]     inMask,
  input  logic [PACK*SUM_W-1:0]      inSum,
  input  logic [PACK*SQ_W-1:0]       inSq,
  input  logic [PACK*PIX_W-1:0]      inPix,
  output logic                       outValid,
  output logic [PACK*WIN_MASK_W-1:0] outMask,
  output logic [PACK*SUM_W-1:0]      outSum,
  output logic [PACK*SQ_W-1:0]       outSq,
  output logic [PACK*PIX_W-1:0]      outPix
);

  wsumCtl_t ctl;

  wsum_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .PACK(PACK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl)
  );

  wsum_datapath #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .PACK(PACK), .PIX_W(PIX_W),
    .MASK_W(MASK_W), .SUM_W(SUM_W), .SQ_W(SQ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inMask(inMask), .inSum(inSum), .inSq(inSq), .inPix(inPix),
    .outValid(outValid), .outMask(outMask), .outSum(outSum),
    .outSq(outSq), .outPix(outPix)
  );

endmodule

// File: tb/tb_sat_window_sum.sv
module tb_sat_window_sum;

  localparam int W    = 16;
  localparam int H    = 10;
  localparam int P    = 4;
  localparam int NP   = W / P;
  localparam int PW   = 8;
  localparam int MW   = 8;
  localparam int SW   = 16;
  localparam int QW   = 24;
  localparam int WMW  = 6;
  localparam int NFR  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic              inValid;
  logic [P*MW-1:0]   inMask;
  logic [P*SW-1:0]   inSum;
  logic [P*QW-1:0]   inSq;
  logic [P*PW-1:0]   inPix;
  logic              outValid;
  logic [P*WMW-1:0]  outMask;
  logic [P*SW-1:0]   outSum;
  logic [P*QW-1:0]   outSq;
  logic [P*PW-1:0]   outPix;

  sat_window_sum #(.IMG_W(W), .IMG_H(H), .PACK(P), .PIX_W(PW),
                   .MASK_W(MW), .SUM_W(SW), .SQ_W(QW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inMask(inMask), .inSum(inSum), .inSq(inSq), .inPix(inPix),
    .outValid(outValid), .outMask(outMask), .outSum(outSum),
    .outSq(outSq), .outPix(outPix)
  );

  int maskArr [NFR][H][W];
  int valArr  [NFR][H][W];
  int rawArr  [NFR][H][W];
  int inEdge  [NFR][H][NP];
  int lastEdge [NFR];
  int edgeCnt = 0;
  int nChecks = 0;
  int nFails  = 0;
  int mFrame = 0, mRow = 0, mPack = 0;
  int nOut = 0;
  bit finished = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int fieldOf(int f, int r, int c, int kind);
    if (kind == 0) return maskArr[f][r][c];
    if (kind == 1) return valArr[f][r][c];
    return valArr[f][r][c] * valArr[f][r][c];
  endfunction

  function automatic int satOf(int f, int r, int c, int kind);
    int s = 0;
    for (int rr = 0; rr <= r; rr++)
      for (int cc = 0; cc <= c; cc++)
        s += fieldOf(f, rr, cc, kind);
    return s;
  endfunction

  function automatic int winOf(int f, int y, int x, int kind);
    int s = 0;
    for (int rr = y - 3; rr <= y + 3; rr++)
      for (int cc = x - 3; cc <= x + 3; cc++)
        if (rr >= 0 && rr < H && cc >= 0 && cc < W) s += fieldOf(f, rr, cc, kind);
    return s;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      nOut++;
      if (mFrame >= NFR) begin
        nChecks++;
        nFails++;
        $display("FAIL R9 extra output pack: actual 1 expected 0");
      end else begin
        int y, q, expEdge;
        string ttag, ptag;
        y = mRow;
        q = mPack;
        if (y + 3 <= H - 1) begin
          if (q < NP - 1) begin
            expEdge = inEdge[mFrame][y+3][q+1];
            ttag = (mFrame == 0) ? "R5/R12" : "R5";
          end else begin
            expEdge = inEdge[mFrame][y+3][NP-1] + 1;
            ttag = "R6";
          end
        end else begin
          expEdge = lastEdge[mFrame] + 2 + (y - (H - 3)) * NP + q;
          ttag = "R7";
        end
        if (y == 0 && q == 0 && mFrame > 0) ttag = "R11";
        check(ttag, $sformatf("frame %0d row %0d pack %0d edge", mFrame, y, q), edgeCnt, expEdge);
        for (int j = 0; j < P; j++) begin
          int x;
          x = q * P + j;
          if (y < 3 || y > H - 4) ptag = "R4";
          else if (x < 3 || x > W - 4) ptag = "R3";
          else ptag = "R2";
          check(ptag, $sformatf("mask y%0d x%0d", y, x),
                int'(outMask[j*WMW +: WMW]), winOf(mFrame, y, x, 0));
          check(ptag, $sformatf("sum y%0d x%0d", y, x),
                int'(outSum[j*SW +: SW]), winOf(mFrame, y, x, 1));
          check(ptag, $sformatf("sq y%0d x%0d", y, x),
                int'(outSq[j*QW +: QW]), winOf(mFrame, y, x, 2));
          check("R8", $sformatf("pix y%0d x%0d", y, x),
                int'(outPix[j*PW +: PW]), rawArr[mFrame][y][x]);
          if (mFrame == 1)
            check("R10", $sformatf("mask bound y%0d x%0d", y, x),
                  int'(outMask[j*WMW +: WMW] <= 6'd49), 1);
        end
        if (mPack == NP - 1) begin
          mPack = 0;
          if (mRow == H - 1) begin
            mRow = 0;
            mFrame++;
          end else mRow++;
        end else mPack++;
      end
    end
  end

  task automatic drivePack(int f, int r, int p);
    for (int j = 0; j < P; j++) begin
      int c;
      c = p * P + j;
      inMask[j*MW +: MW] = MW'(satOf(f, r, c, 0));
      inSum[j*SW +: SW]  = SW'(satOf(f, r, c, 1));
      inSq[j*QW +: QW]   = QW'(satOf(f, r, c, 2));
      inPix[j*PW +: PW]  = PW'(rawArr[f][r][c]);
    end
    inValid = 1'b1;
  endtask

  initial begin
    for (int f = 0; f < NFR; f++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) begin
          if (f == 1) begin
            maskArr[f][r][c] = 1;
            rawArr[f][r][c]  = 255;
          end else begin
            maskArr[f][r][c] = (($urandom % 5) != 0) ? 1 : 0;
            rawArr[f][r][c]  = int'($urandom % 256);
          end
          valArr[f][r][c] = maskArr[f][r][c] != 0 ? rawArr[f][r][c] : 0;
        end

    rstN    = 1'b0;
    inValid = 1'b0;
    inMask  = '0;
    inSum   = '0;
    inSq    = '0;
    inPix   = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "outValid after reset", int'(outValid), 0);
    end

    for (int f = 0; f < NFR; f++) begin
      for (int r = 0; r < H; r++) begin
        for (int p = 0; p < NP; p++) begin
          if (f > 0 && ($urandom % 3) == 0) begin
            inValid = 1'b0;
            @(negedge clk);
          end
          drivePack(f, r, p);
          inEdge[f][r][p] = edgeCnt + 1;
          @(negedge clk);
        end
      end
      lastEdge[f] = edgeCnt;
      inValid = 1'b0;
      repeat (3 * NP + 1) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R9", "output pack count", nOut, NFR * H * NP);
    check("R9", "frames completed", mFrame, NFR);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule